// File: doc/BRIEF.md
# Two-Channel DAC Input Front-End

This block is the digital input stage of a two-channel 14-bit converter. Each channel has two registers in series. A first-stage capture register takes a data word when a write strobe rises. A second-stage hold register copies that word when an update clock rises, and its contents drive the converter code. Strobe and clock inputs are sampled on the core clock `clk_i`. Each rising edge is found by comparing a line with its value in the previous cycle, so every action happens one core cycle after the edge appears.

A mode input chooses between two ways of working. With `mode_dual_i` high, each channel has its own data bus, write strobe and update clock, and the two channels run independently. With `mode_dual_i` low, the bus of channel A carries alternating words for both channels at twice the update rate, and the four control lines change their meaning:
- `ctl_wr_a_i` becomes a shared write strobe.
- `ctl_clk_a_i` becomes a shared clock.
- `ctl_clk_b_i` becomes a divider reset.
- `ctl_wr_b_i` becomes a steering select.

In this mode the shared clock is divided by two, and both hold registers load together at half the word rate.

Each channel also gives a one-cycle update pulse in the same cycle its code output takes a newly loaded value. A system-level checker uses this pulse to line up the output codes with the expected word sequence.

Top module: `dacfe_top`

## Requirements
- R1: While `rst_ni` is low, both code outputs are 0 and both update pulses are low, with no clock edge needed.
- R2: With `mode_dual_i`=1, a rising `ctl_wr_a_i` captures `a_data_i`, and a later rising `ctl_clk_a_i` moves that word to `code_a_o`. Channel B does the same with `ctl_wr_b_i`, `b_data_i` and `ctl_clk_b_i`.
- R3: With `mode_dual_i`=1, strobes and clocks of one channel never change the code or the update pulse of the other channel.
- R4: When a write rising edge and an update rising edge arrive in the same cycle, the output takes the word captured earlier, and the new word waits for the next update edge.
- R5: With `mode_dual_i`=0, words are taken only from `a_data_i`, and `b_data_i` has no effect. At a rising `ctl_wr_a_i`, the word goes to channel A when `ctl_wr_b_i` is 1 and to channel B when it is 0.
- R6: With `mode_dual_i`=0, both channels load together on every second rising edge of `ctl_clk_a_i`. The first rising edge after the divider has been cleared is the one that loads.
- R7: With `mode_dual_i`=0, while `ctl_clk_b_i` is high, rising edges of the shared clock load nothing, and the divider is held cleared.
- R8: Each load raises the channel's update pulse for exactly one cycle, in the same cycle the new code appears. Outside such a cycle the code does not change.
- R9: Codes are straight binary, with bit 13 as the MSB, and pass through unchanged. The extreme words 0x0000 and 0x3FFF arrive intact.
- R10: Only rising edges act. A write strobe held high over several cycles captures once, and data changes while it stays high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock that samples all control lines |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_dual_i | input | 1 | 1 = dual-port, 0 = interleaved |
| a_data_i | input | 14 | Channel A bus; shared bus in interleaved mode |
| b_data_i | input | 14 | Channel B bus; unused in interleaved mode |
| ctl_wr_a_i | input | 1 | Write strobe A / shared write strobe |
| ctl_clk_a_i | input | 1 | Update clock A / shared clock |
| ctl_clk_b_i | input | 1 | Update clock B / divider reset |
| ctl_wr_b_i | input | 1 | Write strobe B / steering select (1 = A) |
| code_a_o | output | 14 | Converter code, channel A |
| code_b_o | output | 14 | Converter code, channel B |
| upd_a_o | output | 1 | One-cycle pulse when channel A loads |
| upd_b_o | output | 1 | One-cycle pulse when channel B loads |

## Verification
The bench builds the block at its default code width of 14 bits, so the stimulus table can use the real extreme codes 0x0000 and 0x3FFF and bit patterns across the whole word. This width also lets the table run a full dual-port sequence and then an interleaved one. That sequence includes a coincident write and update, a blocked clock edge during divider reset, and the first loading edge after reset ends. All of it runs on one stretch of state, so errors that carry over between modes show up.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  parameter int unsigned CODE_W = 14;
  localparam int unsigned N_CH  = 2;
  localparam int unsigned N_CTL = 4;
  // control line positions in the sampled vector
  localparam int unsigned IDX_WR_A  = 0;
  localparam int unsigned IDX_CLK_A = 1;
  localparam int unsigned IDX_CLK_B = 2;
  localparam int unsigned IDX_WR_B  = 3;
endpackage

// File: rtl/dacfe_edge.sv
module dacfe_edge #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/dacfe_div.sv
module dacfe_div (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic hold_i,
  input  logic tick_i,
  output logic strobe_o
);
  logic ph_q;

  // divided edge = tick while phase is low
  assign strobe_o = en_i & ~hold_i & tick_i & ~ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ph_q <= 1'b0;
    else if (!en_i || hold_i) ph_q <= 1'b0;
    else if (tick_i)          ph_q <= ~ph_q;
  end
endmodule

// File: rtl/dacfe_chan.sv
module dacfe_chan #(
  parameter int unsigned W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] din_i,
  input  logic         load_i,
  output logic [W-1:0] code_o,
  output logic         upd_o
);
  logic [W-1:0] in_q;
  logic [W-1:0] hold_q;
  logic         upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q   <= '0;
      hold_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      if (cap_i)  in_q   <= din_i;
      if (load_i) hold_q <= in_q;  // old word on coincident edges
      upd_q <= load_i;
    end
  end

  assign code_o = hold_q;
  assign upd_o  = upd_q;
endmodule

// File: rtl/dacfe_top.sv
module dacfe_top
  import dacfe_pkg::*;
#(
  parameter int unsigned CodeW = CODE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_dual_i,
  input  logic [CodeW-1:0] a_data_i,
  input  logic [CodeW-1:0] b_data_i,
  input  logic             ctl_wr_a_i,
  input  logic             ctl_clk_a_i,
  input  logic             ctl_clk_b_i,
  input  logic             ctl_wr_b_i,
  output logic [CodeW-1:0] code_a_o,
  output logic [CodeW-1:0] code_b_o,
  output logic             upd_a_o,
  output logic             upd_b_o
);
  logic [N_CTL-1:0] ctl;
  logic [N_CTL-1:0] rise;
  logic             ilv_load;
  logic             ilv_sel;
  logic             ilv_rst;

  logic [CodeW-1:0] dual_din [N_CH];
  logic [CodeW-1:0] code     [N_CH];
  logic [N_CH-1:0]  upd;

  assign ctl[IDX_WR_A]  = ctl_wr_a_i;
  assign ctl[IDX_CLK_A] = ctl_clk_a_i;
  assign ctl[IDX_CLK_B] = ctl_clk_b_i;
  assign ctl[IDX_WR_B]  = ctl_wr_b_i;

  assign ilv_sel = ctl_wr_b_i;
  assign ilv_rst = ctl_clk_b_i;

  assign dual_din[0] = a_data_i;
  assign dual_din[1] = b_data_i;

  dacfe_edge #(.N(N_CTL)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (ctl),
    .rise_o (rise)
  );

  dacfe_div u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (~mode_dual_i),
    .hold_i   (ilv_rst),
    .tick_i   (rise[IDX_CLK_A]),
    .strobe_o (ilv_load)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam int unsigned WrI  = (c == 0) ? IDX_WR_A : IDX_WR_B;
    localparam int unsigned ClkI = (c == 0) ? IDX_CLK_A : IDX_CLK_B;
    localparam logic        SelV = (c == 0);

    logic             cap;
    logic             load;
    logic [CodeW-1:0] din;

    assign cap  = mode_dual_i ? rise[WrI]
                              : (rise[IDX_WR_A] & (ilv_sel == SelV));
    assign din  = mode_dual_i ? dual_din[c] : a_data_i;
    assign load = mode_dual_i ? rise[ClkI] : ilv_load;

    dacfe_chan #(.W(CodeW)) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cap_i  (cap),
      .din_i  (din),
      .load_i (load),
      .code_o (code[c]),
      .upd_o  (upd[c])
    );
  end

  assign code_a_o = code[0];
  assign code_b_o = code[1];
  assign upd_a_o  = upd[0];
  assign upd_b_o  = upd[1];
endmodule

// File: rtl/dacfe_chk.sv
module dacfe_chk #(
  parameter int unsigned CodeW = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_dual_i,
  input logic             ctl_clk_a_i,
  input logic             ctl_clk_b_i,
  input logic [CodeW-1:0] code_a_o,
  input logic [CodeW-1:0] code_b_o,
  input logic             upd_a_o,
  input logic             upd_b_o
);
  assert_clk_a_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_a_o |-> $past(ctl_clk_a_i));

  assert_clk_b_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_b_o && $past(mode_dual_i)) |-> $past(ctl_clk_b_i));

  assert_upd_pair_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_a_o && !$past(mode_dual_i)) |-> upd_b_o);

  assert_rst_block_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(mode_dual_i) && $past(ctl_clk_b_i)) |-> (!upd_a_o && !upd_b_o));

  assert_upd_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_a_o |=> !upd_a_o);

  assert_hold_a_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_a_o |-> $stable(code_a_o));

  assert_hold_b_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_b_o |-> $stable(code_b_o));
endmodule

bind dacfe_top dacfe_chk #(.CodeW(CodeW)) u_dacfe_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_dual_i (mode_dual_i),
  .ctl_clk_a_i (ctl_clk_a_i),
  .ctl_clk_b_i (ctl_clk_b_i),
  .code_a_o    (code_a_o),
  .code_b_o    (code_b_o),
  .upd_a_o     (upd_a_o),
  .upd_b_o     (upd_b_o)
);

// File: tb/dacfe_top_tb_top.sv
module dacfe_top_tb_top;
  localparam int unsigned W = 14;
  localparam int unsigned NV = 30;

  logic         clk = 1'b0;
  logic         rst_ni;
  logic         mode_dual;
  logic [W-1:0] a_data, b_data;
  logic         wr_a, clk_a, clk_b, wr_b;
  logic [W-1:0] code_a, code_b;
  logic         upd_a, upd_b;
  int           total = 0;
  int           bad = 0;

  always #10 clk = ~clk;

  dacfe_top #(.CodeW(W)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mode_dual_i (mode_dual),
    .a_data_i    (a_data),
    .b_data_i    (b_data),
    .ctl_wr_a_i  (wr_a),
    .ctl_clk_a_i (clk_a),
    .ctl_clk_b_i (clk_b),
    .ctl_wr_b_i  (wr_b),
    .code_a_o    (code_a),
    .code_b_o    (code_b),
    .upd_a_o     (upd_a),
    .upd_b_o     (upd_b)
  );

  // {req, mode, a, b, ctl{wa,ca,cb,wb}, exp_a, exp_b, {upd_a,upd_b}}
  localparam logic [66:0] VEC [NV] = '{
    {4'd2, 1'b1,14'h0123,14'h0456,4'b1001,14'h0000,14'h0000,2'b00}, // R2 capture both
    {4'd10,1'b1,14'h0AAA,14'h0BBB,4'b1001,14'h0000,14'h0000,2'b00}, // R10 level held
    {4'd3, 1'b1,14'h0AAA,14'h0BBB,4'b0100,14'h0123,14'h0000,2'b10}, // R3 A only
    {4'd8, 1'b1,14'h0AAA,14'h0BBB,4'b0000,14'h0123,14'h0000,2'b00}, // R8
    {4'd3, 1'b1,14'h0AAA,14'h0BBB,4'b0010,14'h0123,14'h0456,2'b01}, // R3 B only
    {4'd4, 1'b1,14'h3FFF,14'h0000,4'b1100,14'h0123,14'h0456,2'b10}, // R4 coincident
    {4'd8, 1'b1,14'h3FFF,14'h0000,4'b0000,14'h0123,14'h0456,2'b00}, // R8
    {4'd9, 1'b1,14'h3FFF,14'h0000,4'b0100,14'h3FFF,14'h0456,2'b10}, // R9 max code
    {4'd2, 1'b1,14'h0000,14'h0000,4'b1000,14'h3FFF,14'h0456,2'b00}, // R2
    {4'd2, 1'b1,14'h0000,14'h1555,4'b0001,14'h3FFF,14'h0456,2'b00}, // R2
    {4'd9, 1'b1,14'h0000,14'h1555,4'b0110,14'h0000,14'h1555,2'b11}, // R9 zero code
    {4'd8, 1'b1,14'h0000,14'h1555,4'b0000,14'h0000,14'h1555,2'b00}, // R8
    {4'd5, 1'b0,14'h2001,14'h3FFF,4'b1001,14'h0000,14'h1555,2'b00}, // R5 sel=1 -> A
    {4'd5, 1'b0,14'h0777,14'h1111,4'b0000,14'h0000,14'h1555,2'b00}, // R5
    {4'd5, 1'b0,14'h0777,14'h1111,4'b1000,14'h0000,14'h1555,2'b00}, // R5 sel=0 -> B
    {4'd5, 1'b0,14'h0777,14'h1111,4'b0000,14'h0000,14'h1555,2'b00}, // R5
    {4'd6, 1'b0,14'h0777,14'h1111,4'b0100,14'h2001,14'h0777,2'b11}, // R6 first rise loads
    {4'd6, 1'b0,14'h0777,14'h1111,4'b0000,14'h2001,14'h0777,2'b00}, // R6
    {4'd6, 1'b0,14'h0777,14'h1111,4'b0100,14'h2001,14'h0777,2'b00}, // R6 second rise idle
    {4'd6, 1'b0,14'h1234,14'h1111,4'b0001,14'h2001,14'h0777,2'b00}, // R6
    {4'd5, 1'b0,14'h1234,14'h1111,4'b1001,14'h2001,14'h0777,2'b00}, // R5
    {4'd6, 1'b0,14'h1234,14'h1111,4'b0101,14'h1234,14'h0777,2'b11}, // R6 third rise loads
    {4'd6, 1'b0,14'h1234,14'h1111,4'b0001,14'h1234,14'h0777,2'b00}, // R6
    {4'd7, 1'b0,14'h1234,14'h1111,4'b0010,14'h1234,14'h0777,2'b00}, // R7 reset high
    {4'd7, 1'b0,14'h1234,14'h1111,4'b0110,14'h1234,14'h0777,2'b00}, // R7 blocked rise
    {4'd7, 1'b0,14'h1234,14'h1111,4'b0010,14'h1234,14'h0777,2'b00}, // R7
    {4'd7, 1'b0,14'h1234,14'h1111,4'b0000,14'h1234,14'h0777,2'b00}, // R7 release
    {4'd5, 1'b0,14'h0042,14'h1111,4'b1000,14'h1234,14'h0777,2'b00}, // R5
    {4'd7, 1'b0,14'h0042,14'h1111,4'b0100,14'h1234,14'h0042,2'b11}, // R7 cleared divider
    {4'd8, 1'b0,14'h0042,14'h1111,4'b0000,14'h1234,14'h0042,2'b00}  // R8
  };

  task automatic check(input string what, input int req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; mode_dual = 1'b1;
    a_data = '0; b_data = '0;
    wr_a = 0; clk_a = 0; clk_b = 0; wr_b = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("reset code_a", 1, 32'(code_a), 32'h0);
    check("reset code_b", 1, 32'(code_b), 32'h0);
    check("reset upd", 1, {30'h0, upd_a, upd_b}, 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < int'(NV); i++) begin
      mode_dual = VEC[i][62];
      a_data    = VEC[i][61:48];
      b_data    = VEC[i][47:34];
      wr_a      = VEC[i][33];
      clk_a     = VEC[i][32];
      clk_b     = VEC[i][31];
      wr_b      = VEC[i][30];
      @(negedge clk);
      check($sformatf("row %0d code_a", i), int'(VEC[i][66:63]), 32'(code_a), 32'(VEC[i][29:16]));
      check($sformatf("row %0d code_b", i), int'(VEC[i][66:63]), 32'(code_b), 32'(VEC[i][15:2]));
      check($sformatf("row %0d upd_a", i), int'(VEC[i][66:63]), 32'(upd_a), 32'(VEC[i][1]));
      check($sformatf("row %0d upd_b", i), int'(VEC[i][66:63]), 32'(upd_b), 32'(VEC[i][0]));
    end

    // R1: asynchronous reset mid-run clears codes without a clock edge
    #3 rst_ni = 1'b0;
    #1;
    check("async reset code_a", 1, 32'(code_a), 32'h0);
    check("async reset code_b", 1, 32'(code_b), 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R2 / R10: dual mode after reset, held strobe captures once
    mode_dual = 1'b1; a_data = 14'h2ABC; wr_a = 1'b1;
    @(negedge clk);
    a_data = 14'h0001;
    @(negedge clk);
    clk_a = 1'b1;
    @(negedge clk);
    check("post-reset code_a", 10, 32'(code_a), 32'h2ABC);
    check("post-reset upd_a", 2, 32'(upd_a), 32'h1);
    check("post-reset code_b", 3, 32'(code_b), 32'h0);
    wr_a = 1'b0; clk_a = 1'b0;
    @(negedge clk);
    check("post-reset upd_a low", 8, 32'(upd_a), 32'h0);
    finish_run();
  end
endmodule